// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block is the automatic hardware handshake for one serial channel. On the receive side it drives an active-low request-to-send pin from the receive buffer fill count. It uses a hysteresis window derived from a ladder of four trigger levels. The pin is raised when the count reaches the rung above the selected trigger. It is released only when the count falls to the rung below the selected trigger. The receive buffer keeps taking characters while the pin is raised, until it is full. The block only signals the far end and never blocks writes.

On the transmit side it synchronizes the active-low clear-to-send pin and produces a transmit-allow level for the serializer. When the far end deasserts clear-to-send during a character, the pause waits for that character's stop bit to finish before the next start is blocked. The pause ends as soon as the synchronized pin is low again. A rising edge of the synchronized pin sets a sticky status flag when its interrupt enable is on. A status-read strobe clears the flag.

Receive state machine:
- `RX_OPEN` (pin low) moves to `RX_HELD` when the count is at or above the upper threshold.
- `RX_HELD` (pin high) moves back to `RX_OPEN` when the count is at or below the lower threshold.
- Disabling the automatic mode forces `RX_OPEN`.

Transmit state machine:
- `TX_RUN` moves to `TX_DRAIN` on a high synchronized pin while a character is active, or to `TX_HOLD` when the transmitter is idle.
- `TX_DRAIN` moves to `TX_HOLD` on the stop-done strobe, or back to `TX_RUN` if the pin returns low.
- `TX_HOLD` moves back to `TX_RUN` when the pin is low.
- Disabling the automatic mode forces `TX_RUN`.

Top module: `uart_autoflow`

## Requirements
- R1: After reset, rts_n is 0 (with automatic RTS on), tx_allow is 1 and fc_flag is 0.
- R2: With auto_rts_en=1, rts_n becomes 1 one cycle after rx_level reaches the upper threshold: trig_sel 0→16, 1→56, 2→60, 3→60.
- R3: With auto_rts_en=1 and rts_n=1, rts_n returns to 0 one cycle after rx_level is at or below the lower threshold: trig_sel 0→0, 1→8, 2→16, 3→56.
- R4: With auto_rts_en=1, a level strictly between the two thresholds leaves rts_n unchanged. This includes a full buffer of 128 after the pin is raised.
- R5: With auto_rts_en=0, rts_n equals sw_rts_n in the same cycle. On re-enable, the receive machine starts from `RX_OPEN`.
- R6: cts_n passes through a two-flop synchronizer. No output reacts to it earlier than the third rising edge after a change.
- R7: If cts_n rises while tx_active=1, tx_allow stays 1 until the stop_done strobe. It falls one cycle after that strobe.
- R8: If cts_n rises while tx_active=0, tx_allow falls at the third edge after the change.
- R9: With auto_cts_en=1, tx_allow returns to 1 at the third edge after cts_n returns low, from either the paused or the draining state.
- R10: With auto_cts_en=0, tx_allow is 1 one cycle later and stays 1 whatever cts_n does.
- R11: A synchronized rising edge of cts_n sets fc_flag at the third edge after the change, only if fc_irq_en=1. The flag stays set until stat_rd clears it one cycle later. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | CNT_W (8) | Receive buffer fill count |
| trig_sel | input | 2 | Selected trigger rung (0..3 = 8/16/56/60) |
| auto_rts_en | input | 1 | Enable automatic RTS |
| auto_cts_en | input | 1 | Enable automatic CTS pausing |
| sw_rts_n | input | 1 | Software RTS pin value used when automatic RTS is off |
| fc_irq_en | input | 1 | Allow the CTS status flag to set |
| cts_n | input | 1 | Asynchronous active-low clear-to-send pin |
| tx_active | input | 1 | A character is being shifted out |
| stop_done | input | 1 | One-cycle strobe: stop bit of current character finished |
| stat_rd | input | 1 | One-cycle strobe clearing the status flag |
| rts_n | output | 1 | Active-low request-to-send pin |
| tx_allow | output | 1 | Transmitter may start or continue characters |
| fc_flag | output | 1 | Sticky CTS-deasserted status flag |

## Verification
Each result has a fixed due cycle after its stimulus:
- rts_n under manual control is due in the same cycle as sw_rts_n.
- Hysteresis changes of rts_n are due one edge after the level changes.
- tx_allow changes from a stop_done strobe or a disable of auto_cts_en are due one edge after the strobe or the disable.
- Anything caused by cts_n is due on the third edge, because of the two synchronizer flops and the state register.

The driver records every expectation with its due cycle, counted from the edge that follows the stimulus. The monitor compares it only in that cycle, shortly after the falling edge. Checks one cycle before the due cycle confirm that nothing reacts early.

// File: rtl/autoflow_pkg.sv
package autoflow_pkg;
    typedef enum logic {
        RX_OPEN,
        RX_HELD
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_RUN,
        TX_DRAIN,
        TX_HOLD
    } tx_state_e;
endpackage

// File: rtl/autoflow_cts_sync.sv
module autoflow_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic cts_high,
    output logic cts_rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin_n};
            prev  <= chain[STAGES-1];
        end
    end

    assign cts_high = chain[STAGES-1];
    assign cts_rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/autoflow_rts_ctl.sv
module autoflow_rts_ctl
    import autoflow_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TRIG_A = 8,
    parameter int TRIG_B = 16,
    parameter int TRIG_C = 56,
    parameter int TRIG_D = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_rts_n,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_level,
    output logic             rts_n
);
    localparam logic [CNT_W-1:0] RUNG_A = CNT_W'(TRIG_A);
    localparam logic [CNT_W-1:0] RUNG_B = CNT_W'(TRIG_B);
    localparam logic [CNT_W-1:0] RUNG_C = CNT_W'(TRIG_C);
    localparam logic [CNT_W-1:0] RUNG_D = CNT_W'(TRIG_D);

    rx_state_e        state, state_nxt;
    logic [CNT_W-1:0] thr_hi, thr_lo;

    // Upper threshold is the next rung up, lower is the next rung down.
    always_comb begin
        unique case (trig_sel)
            2'd0: begin thr_hi = RUNG_B; thr_lo = '0;     end
            2'd1: begin thr_hi = RUNG_C; thr_lo = RUNG_A; end
            2'd2: begin thr_hi = RUNG_D; thr_lo = RUNG_B; end
            default: begin thr_hi = RUNG_D; thr_lo = RUNG_C; end
        endcase
    end

    always_comb begin
        state_nxt = state;
        if (!auto_en) begin
            state_nxt = RX_OPEN;
        end else begin
            unique case (state)
                RX_OPEN: if (rx_level >= thr_hi) state_nxt = RX_HELD;
                RX_HELD: if (rx_level <= thr_lo) state_nxt = RX_OPEN;
                default: state_nxt = RX_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_OPEN;
        else        state <= state_nxt;
    end

    always_comb begin
        if (auto_en) rts_n = (state == RX_HELD);
        else         rts_n = sw_rts_n;
    end
endmodule

// File: rtl/autoflow_tx_gate.sv
module autoflow_tx_gate
    import autoflow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_high,
    input  logic tx_active,
    input  logic stop_done,
    output logic tx_allow
);
    tx_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        if (!auto_en) begin
            state_nxt = TX_RUN;
        end else begin
            unique case (state)
                TX_RUN:   if (cts_high) state_nxt = tx_active ? TX_DRAIN : TX_HOLD;
                TX_DRAIN: begin
                    if (!cts_high)      state_nxt = TX_RUN;
                    else if (stop_done) state_nxt = TX_HOLD;
                end
                TX_HOLD:  if (!cts_high) state_nxt = TX_RUN;
                default:  state_nxt = TX_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        tx_allow = (state != TX_HOLD);
    end
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow #(
    parameter int FIFO_DEPTH  = 128,
    parameter int TRIG_A      = 8,
    parameter int TRIG_B      = 16,
    parameter int TRIG_C      = 56,
    parameter int TRIG_D      = 60,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [1:0]       trig_sel,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             sw_rts_n,
    input  logic             fc_irq_en,
    input  logic             cts_n,
    input  logic             tx_active,
    input  logic             stop_done,
    input  logic             stat_rd,
    output logic             rts_n,
    output logic             tx_allow,
    output logic             fc_flag
);
    logic cts_high, cts_rise;

    autoflow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (cts_n),
        .cts_high (cts_high),
        .cts_rise (cts_rise)
    );

    autoflow_rts_ctl #(
        .CNT_W (CNT_W),
        .TRIG_A(TRIG_A), .TRIG_B(TRIG_B), .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
    ) u_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_rts_en),
        .sw_rts_n (sw_rts_n),
        .trig_sel (trig_sel),
        .rx_level (rx_level),
        .rts_n    (rts_n)
    );

    autoflow_tx_gate u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_cts_en),
        .cts_high  (cts_high),
        .tx_active (tx_active),
        .stop_done (stop_done),
        .tx_allow  (tx_allow)
    );

    // Sticky status: a new edge outranks a read in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      fc_flag <= 1'b0;
        else if (cts_rise && fc_irq_en)  fc_flag <= 1'b1;
        else if (stat_rd)                fc_flag <= 1'b0;
    end
endmodule

// File: rtl/autoflow_chk.sv
module autoflow_chk #(
    parameter int CNT_W  = 8,
    parameter int TRIG_A = 8,
    parameter int TRIG_B = 16,
    parameter int TRIG_C = 56,
    parameter int TRIG_D = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_level,
    input logic [1:0]       trig_sel,
    input logic             auto_rts_en,
    input logic             auto_cts_en,
    input logic             fc_irq_en,
    input logic             tx_active,
    input logic             stop_done,
    input logic             stat_rd,
    input logic             rts_n,
    input logic             tx_allow,
    input logic             fc_flag
);
    function automatic int upper_of(logic [1:0] s);
        case (s)
            2'd0:    return TRIG_B;
            2'd1:    return TRIG_C;
            default: return TRIG_D;
        endcase
    endfunction

    function automatic int lower_of(logic [1:0] s);
        case (s)
            2'd0:    return 0;
            2'd1:    return TRIG_A;
            2'd2:    return TRIG_B;
            default: return TRIG_C;
        endcase
    endfunction

    p_raise_at_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && int'(rx_level) >= upper_of(trig_sel)) |=> (rts_n || !auto_rts_en));

    p_release_at_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && int'(rx_level) <= lower_of(trig_sel)) |=> (!rts_n || !auto_rts_en));

    p_band_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && int'(rx_level) > lower_of(trig_sel) && int'(rx_level) < upper_of(trig_sel))
        |=> (!auto_rts_en || $stable(rts_n)));

    p_pause_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_allow) |-> $past(stop_done || !tx_active));

    p_manual_cts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |=> tx_allow);

    p_flag_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fc_flag) |-> $past(fc_irq_en));

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_flag && !stat_rd) |=> fc_flag);
endmodule

bind uart_autoflow autoflow_chk #(
    .CNT_W(CNT_W), .TRIG_A(TRIG_A), .TRIG_B(TRIG_B), .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .fc_irq_en(fc_irq_en),
    .tx_active(tx_active), .stop_done(stop_done), .stat_rd(stat_rd),
    .rts_n(rts_n), .tx_allow(tx_allow), .fc_flag(fc_flag)
);

// File: tb/tb_uart_autoflow.sv
module tb_uart_autoflow;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_level = '0;
    logic [1:0] trig_sel = '0;
    logic       auto_rts_en = 1'b1, auto_cts_en = 1'b1, sw_rts_n = 1'b1, fc_irq_en = 1'b1;
    logic       cts_n = 1'b0, tx_active = 1'b0, stop_done = 1'b0, stat_rd = 1'b0;
    logic       rts_n, tx_allow, fc_flag;

    int  cyc = 0;
    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    typedef struct {
        int    due;
        int    kind;   // 0 rts_n, 1 tx_allow, 2 fc_flag
        logic  val;
        string tag;
    } item_t;
    item_t sb[$];

    uart_autoflow dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_sel(trig_sel),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .sw_rts_n(sw_rts_n),
        .fc_irq_en(fc_irq_en), .cts_n(cts_n), .tx_active(tx_active),
        .stop_done(stop_done), .stat_rd(stat_rd),
        .rts_n(rts_n), .tx_allow(tx_allow), .fc_flag(fc_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_out(int d, int kind, logic v, string tag);
        sb.push_back('{cyc + d, kind, v, tag});
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_level(int l, logic e, string tag);
        @(negedge clk);
        rx_level = 8'(l);
        expect_out(1, 0, e, tag);
    endtask

    // Monitor: compares each expectation in its due cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    logic got;
                    got = (sb[i].kind == 0) ? rts_n : (sb[i].kind == 1) ? tx_allow : fc_flag;
                    checks++;
                    if (got !== sb[i].val) begin
                        failures++;
                        $display("FAIL %s out%0d cyc=%0d actual=%b expected=%b",
                                 sb[i].tag, sb[i].kind, cyc, got, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_out(0, 0, 1'b0, "R1");
        expect_out(0, 1, 1'b1, "R1");
        expect_out(0, 2, 1'b0, "R1");

        // trig 8: upper 16, lower 0
        set_level(15, 1'b0, "R4");
        set_level(16, 1'b1, "R2");
        set_level(5,  1'b1, "R4");
        set_level(0,  1'b0, "R3");
        // trig 16: upper 56, lower 8
        @(negedge clk); trig_sel = 2'd1;
        set_level(55, 1'b0, "R4");
        set_level(56, 1'b1, "R2");
        set_level(9,  1'b1, "R4");
        set_level(8,  1'b0, "R3");
        // trig 56: upper 60, lower 16
        @(negedge clk); trig_sel = 2'd2;
        set_level(59,  1'b0, "R4");
        set_level(60,  1'b1, "R2");
        set_level(128, 1'b1, "R4");
        set_level(17,  1'b1, "R4");
        set_level(16,  1'b0, "R3");
        // trig 60: upper 60, lower 56
        @(negedge clk); trig_sel = 2'd3;
        set_level(59, 1'b0, "R4");
        set_level(60, 1'b1, "R2");
        set_level(57, 1'b1, "R4");
        set_level(56, 1'b0, "R3");

        // R5 manual RTS
        @(negedge clk); auto_rts_en = 1'b0; sw_rts_n = 1'b0; rx_level = 8'd100;
        expect_out(0, 0, 1'b0, "R5");
        @(negedge clk); sw_rts_n = 1'b1;
        expect_out(0, 0, 1'b1, "R5");
        @(negedge clk); sw_rts_n = 1'b0;
        expect_out(0, 0, 1'b0, "R5");
        @(negedge clk); auto_rts_en = 1'b1;
        expect_out(0, 0, 1'b0, "R5");
        expect_out(1, 0, 1'b1, "R5");
        tick(1);
        set_level(0, 1'b0, "R3");

        // R8 CTS rises while idle; R6 no early reaction; R11 flag
        @(negedge clk); cts_n = 1'b1;
        expect_out(2, 1, 1'b1, "R6");
        expect_out(2, 2, 1'b0, "R6");
        expect_out(3, 1, 1'b0, "R8");
        expect_out(3, 2, 1'b1, "R11");
        tick(4);
        stat_rd = 1'b1;
        expect_out(0, 2, 1'b1, "R11");
        expect_out(1, 2, 1'b0, "R11");
        @(negedge clk); stat_rd = 1'b0;
        // R9 resume from hold
        @(negedge clk); cts_n = 1'b0;
        expect_out(2, 1, 1'b0, "R9");
        expect_out(3, 1, 1'b1, "R9");
        tick(4);

        // R7 CTS rises mid-character
        tx_active = 1'b1; cts_n = 1'b1;
        expect_out(3, 1, 1'b1, "R7");
        expect_out(5, 1, 1'b1, "R7");
        expect_out(3, 2, 1'b1, "R11");
        tick(6);
        stop_done = 1'b1;
        expect_out(0, 1, 1'b1, "R7");
        expect_out(1, 1, 1'b0, "R7");
        @(negedge clk); stop_done = 1'b0; tx_active = 1'b0; stat_rd = 1'b1;
        expect_out(1, 2, 1'b0, "R11");
        @(negedge clk); stat_rd = 1'b0; cts_n = 1'b0;
        expect_out(3, 1, 1'b1, "R9");
        tick(4);

        // R9 resume from draining
        tx_active = 1'b1; cts_n = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        tick(3);
        cts_n = 1'b0;
        expect_out(3, 1, 1'b1, "R9");
        tick(4);
        stop_done = 1'b1;
        expect_out(1, 1, 1'b1, "R9");
        @(negedge clk); stop_done = 1'b0; tx_active = 1'b0; stat_rd = 1'b1;
        expect_out(1, 2, 1'b0, "R11");
        @(negedge clk); stat_rd = 1'b0;
        tick(1);

        // R11 interrupt disabled: no flag, pause still happens
        fc_irq_en = 1'b0; cts_n = 1'b1;
        expect_out(3, 2, 1'b0, "R11");
        expect_out(4, 2, 1'b0, "R11");
        expect_out(3, 1, 1'b0, "R8");
        tick(5);
        cts_n = 1'b0;
        expect_out(3, 1, 1'b1, "R9");
        tick(5);

        // R11 set outranks clear in the same cycle
        fc_irq_en = 1'b1; cts_n = 1'b1;
        tick(2);
        stat_rd = 1'b1;
        expect_out(1, 2, 1'b1, "R11");
        @(negedge clk); stat_rd = 1'b0;
        expect_out(2, 2, 1'b1, "R11");
        tick(3);
        cts_n = 1'b0;
        tick(4);

        // R10 auto CTS off
        fc_irq_en = 1'b0; auto_cts_en = 1'b0; cts_n = 1'b1;
        expect_out(3, 1, 1'b1, "R10");
        expect_out(5, 1, 1'b1, "R10");
        tick(6);
        // re-enable with pin high and idle: pause follows
        auto_cts_en = 1'b1;
        expect_out(0, 1, 1'b1, "R10");
        expect_out(1, 1, 1'b0, "R8");
        tick(2);
        auto_cts_en = 1'b0;
        expect_out(1, 1, 1'b1, "R10");
        tick(3);

        finished = 1'b1;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule